// File: doc/BRIEF.md
# Tear-Safe Staged Write Sequencer

This block carries out writes of one to eight bytes into a small nonvolatile byte array so that losing power during a write never leaves the destination holding a mix of old and new bytes. With the safe mode enabled, a write goes through three steps. First the destination address, the byte count and the payload are programmed into a persistent staging record. Next a valid flag in that record is set. The payload is then copied one byte at a time to the destination, and the flag is cleared as the final step. Every programming step takes a fixed number of clock cycles to complete. With the safe mode disabled, all bytes of the write are programmed directly into the destination during a single write cycle.

A power-fail input aborts whatever step is running. While that input is high the block sits in an off state. When it falls, the block behaves as if power had just come up. If the staging flag is still set, the block replays the copy from the staging record and then clears the flag. The host polls a single busy output to learn when a write or a recovery has finished. A combinational read port exposes the destination array. The synchronous reset returns the array to its erased state, with every byte reading 0xFF and the flag clear.

Top module: `tear_safe_writer`

## Requirements
- R1: After reset `busy` is low and every destination byte reads 0xFF.
- R2: A request accepted while idle with `safe_en` low writes byte i of `wr_data` (bits 8i+7..8i) to address `wr_addr`+i for i from 0 to `wr_cnt` (count = `wr_cnt`+1). Addresses wrap modulo 2^ADDR_W. `busy` is high for exactly WR_CYCLES clock edges after the accepting edge.
- R3: A request accepted while idle with `safe_en` high leaves the destination with the same contents as R2. `busy` stays high for exactly WR_CYCLES*(count+3) edges after the accepting edge. These cycles cover staging, flag set, one cycle per byte copied, and flag clear.
- R4: A request raised while `busy` is high is ignored. It changes no memory byte and does not lengthen the running write.
- R5: While `pwr_fail` is high, `busy` is high. A programming step whose last cycle coincides with `pwr_fail` does not take effect.
- R6: When `pwr_fail` falls and the staging flag is set, the block replays the copy and clears the flag, staying busy for 1+WR_CYCLES*(count+1) edges. When the flag is clear, `busy` falls after one edge.
- R7: A safe-mode write interrupted by `pwr_fail` at edge k after acceptance leaves the whole destination window holding the new data after restart when k > 2*WR_CYCLES. For smaller k the whole window holds the old data.
- R8: A direct write interrupted by `pwr_fail` before its write cycle completes leaves the destination unchanged.
- R9: Bytes outside the addressed window are never changed by a write, an interruption or a recovery.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; erases the array and the staging record |
| pwr_fail | input | 1 | High while supply is lost; aborts any step |
| wr_req | input | 1 | Write request, sampled while idle |
| safe_en | input | 1 | 1: staged tear-safe write, 0: direct write |
| wr_addr | input | ADDR_W | First destination byte address |
| wr_cnt | input | CNT_W | Byte count minus one |
| wr_data | input | 8*MAX_BYTES | Payload, byte i in bits 8i+7..8i |
| busy | output | 1 | High while a write, recovery or power loss is in progress |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Destination byte at `rd_addr` |

## Verification
The critical coincidence is a power failure landing in the same cycle as the completion of a programming step, most importantly the one that sets the staging flag. The bench sweeps the failure edge over every cycle of a safe write for three byte counts, including the exact edges where the flag set and flag clear would complete. From the edge number alone it predicts whether the flag became persistent, how long recovery keeps the block busy, and whether the window ends up all old or all new. It then compares the whole array against its own shadow copy.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STAGE,
        ST_ARM,
        ST_COPY,
        ST_DISARM,
        ST_DIRECT,
        ST_OFF
    } tsw_state_e;
endpackage

// File: rtl/tsw_wtimer.sv
module tsw_wtimer #(
    parameter int WR_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic done
);
    localparam int CW = (WR_CYCLES > 1) ? $clog2(WR_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(WR_CYCLES - 1);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (abort) begin
            t_d.run = 1'b0;
        end else if (start) begin
            t_d.run = 1'b1;
            t_d.cnt = LAST;
        end else if (t_q.run) begin
            if (t_q.cnt == '0) t_d.run = 1'b0;
            else               t_d.cnt = t_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign done = t_q.run && (t_q.cnt == '0);

    // R5: a power failure halts the write-cycle timer
    a_r5_abort_halts: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !t_q.run);
    // R3: the countdown never exceeds one write-cycle length
    a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.run |-> (t_q.cnt <= LAST));
endmodule

// File: rtl/tsw_nvm.sv
module tsw_nvm #(
    parameter int ADDR_W    = 6,
    parameter int MAX_BYTES = 8,
    parameter int CNT_W     = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   stage_we,
    input  logic                   flag_we,
    input  logic                   flag_val,
    input  logic                   byte_we,
    input  logic [ADDR_W-1:0]      byte_addr,
    input  logic [7:0]             byte_data,
    input  logic                   page_we,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [CNT_W-1:0]       req_cnt,
    input  logic [8*MAX_BYTES-1:0] req_data,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [7:0]             rd_data,
    output logic [ADDR_W-1:0]      rec_addr,
    output logic [CNT_W-1:0]       rec_cnt,
    output logic [8*MAX_BYTES-1:0] rec_data,
    output logic                   rec_valid
);
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic                   valid;
        logic [ADDR_W-1:0]      addr;
        logic [CNT_W-1:0]       cnt;
        logic [8*MAX_BYTES-1:0] data;
    } rec_t;

    logic [7:0] mem_d [DEPTH];
    logic [7:0] mem_q [DEPTH];
    rec_t       rec_d, rec_q;

    always_comb begin
        mem_d = mem_q;
        rec_d = rec_q;
        if (stage_we) begin
            rec_d.addr = req_addr;
            rec_d.cnt  = req_cnt;
            rec_d.data = req_data;
        end
        if (flag_we) rec_d.valid = flag_val;
        if (byte_we) mem_d[byte_addr] = byte_data;
        if (page_we) begin
            for (int i = 0; i < MAX_BYTES; i++) begin
                if (i <= int'(req_cnt))
                    mem_d[req_addr + ADDR_W'(i)] = req_data[8*i +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
            rec_q <= '0;
        end else begin
            mem_q <= mem_d;
            rec_q <= rec_d;
        end
    end

    assign rd_data   = mem_q[rd_addr];
    assign rec_addr  = rec_q.addr;
    assign rec_cnt   = rec_q.cnt;
    assign rec_data  = rec_q.data;
    assign rec_valid = rec_q.valid;

    // R7: the flag is only ever armed from the cleared state
    a_r7_arm_from_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && flag_val) |-> !rec_q.valid);
    // R9: per-byte copy and direct page write never overlap
    a_r9_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_we && page_we));
endmodule

// File: rtl/tsw_ctrl.sv
module tsw_ctrl #(
    parameter int ADDR_W    = 6,
    parameter int MAX_BYTES = 8,
    parameter int CNT_W     = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pwr_fail,
    input  logic                   wr_req,
    input  logic                   safe_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [CNT_W-1:0]       wr_cnt,
    input  logic [8*MAX_BYTES-1:0] wr_data,
    input  logic                   tmr_done,
    output logic                   tmr_start,
    input  logic [ADDR_W-1:0]      rec_addr,
    input  logic [CNT_W-1:0]       rec_cnt,
    input  logic [8*MAX_BYTES-1:0] rec_data,
    input  logic                   rec_valid,
    output logic                   stage_we,
    output logic                   flag_we,
    output logic                   flag_val,
    output logic                   byte_we,
    output logic [ADDR_W-1:0]      byte_addr,
    output logic [7:0]             byte_data,
    output logic                   page_we,
    output logic [ADDR_W-1:0]      req_addr,
    output logic [CNT_W-1:0]       req_cnt,
    output logic [8*MAX_BYTES-1:0] req_data,
    output logic                   busy
);
    import tsw_pkg::*;

    typedef struct packed {
        tsw_state_e             state;
        logic [CNT_W-1:0]       idx;
        logic [ADDR_W-1:0]      addr;
        logic [CNT_W-1:0]       cnt;
        logic [8*MAX_BYTES-1:0] data;
    } ctl_t;

    ctl_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        tmr_start = 1'b0;
        stage_we  = 1'b0;
        flag_we   = 1'b0;
        flag_val  = 1'b0;
        byte_we   = 1'b0;
        page_we   = 1'b0;
        if (pwr_fail) begin
            s_d.state = ST_OFF;
        end else begin
            unique case (s_q.state)
                ST_IDLE: if (wr_req) begin
                    s_d.addr  = wr_addr;
                    s_d.cnt   = wr_cnt;
                    s_d.data  = wr_data;
                    s_d.state = safe_en ? ST_STAGE : ST_DIRECT;
                    tmr_start = 1'b1;
                end
                ST_STAGE: if (tmr_done) begin
                    stage_we  = 1'b1;
                    s_d.state = ST_ARM;
                    tmr_start = 1'b1;
                end
                ST_ARM: if (tmr_done) begin
                    flag_we   = 1'b1;
                    flag_val  = 1'b1;
                    s_d.idx   = '0;
                    s_d.state = ST_COPY;
                    tmr_start = 1'b1;
                end
                ST_COPY: if (tmr_done) begin
                    byte_we   = 1'b1;
                    tmr_start = 1'b1;
                    if (s_q.idx == rec_cnt) s_d.state = ST_DISARM;
                    else                    s_d.idx   = s_q.idx + 1'b1;
                end
                ST_DISARM: if (tmr_done) begin
                    flag_we   = 1'b1;
                    s_d.state = ST_IDLE;
                end
                ST_DIRECT: if (tmr_done) begin
                    page_we   = 1'b1;
                    s_d.state = ST_IDLE;
                end
                ST_OFF: begin
                    if (rec_valid) begin
                        s_d.idx   = '0;
                        s_d.state = ST_COPY;
                        tmr_start = 1'b1;
                    end else begin
                        s_d.state = ST_IDLE;
                    end
                end
                default: s_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign byte_addr = rec_addr + ADDR_W'(s_q.idx);
    assign byte_data = rec_data[{s_q.idx, 3'b000} +: 8];
    assign req_addr  = s_q.addr;
    assign req_cnt   = s_q.cnt;
    assign req_data  = s_q.data;
    assign busy      = (s_q.state != ST_IDLE);

    // R5: a power failure always lands the sequencer in the off state
    a_r5_fail_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> (s_q.state == ST_OFF));
    // R6: restart with an armed record goes straight to the replayed copy
    a_r6_replay_on_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_OFF && !pwr_fail && rec_valid) |=> (s_q.state == ST_COPY));
    // R3: destination bytes are copied only while the record is armed
    a_r3_copy_under_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_COPY) |-> rec_valid);
    // R7: an idle sequencer never leaves an armed record behind
    a_r7_idle_means_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_IDLE) |-> !rec_valid);
endmodule

// File: rtl/tear_safe_writer.sv
module tear_safe_writer #(
    parameter int ADDR_W    = 6,
    parameter int MAX_BYTES = 8,
    parameter int WR_CYCLES = 3,
    localparam int CNT_W    = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pwr_fail,
    input  logic                   wr_req,
    input  logic                   safe_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [CNT_W-1:0]       wr_cnt,
    input  logic [8*MAX_BYTES-1:0] wr_data,
    output logic                   busy,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [7:0]             rd_data
);
    logic                   tmr_start, tmr_done;
    logic                   stage_we, flag_we, flag_val, byte_we, page_we;
    logic [ADDR_W-1:0]      byte_addr, req_addr, rec_addr;
    logic [7:0]             byte_data;
    logic [CNT_W-1:0]       req_cnt, rec_cnt;
    logic [8*MAX_BYTES-1:0] req_data, rec_data;
    logic                   rec_valid;

    tsw_wtimer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .abort(pwr_fail), .done(tmr_done)
    );

    tsw_ctrl #(.ADDR_W(ADDR_W), .MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .wr_req(wr_req),
        .safe_en(safe_en), .wr_addr(wr_addr), .wr_cnt(wr_cnt), .wr_data(wr_data),
        .tmr_done(tmr_done), .tmr_start(tmr_start),
        .rec_addr(rec_addr), .rec_cnt(rec_cnt), .rec_data(rec_data), .rec_valid(rec_valid),
        .stage_we(stage_we), .flag_we(flag_we), .flag_val(flag_val),
        .byte_we(byte_we), .byte_addr(byte_addr), .byte_data(byte_data),
        .page_we(page_we), .req_addr(req_addr), .req_cnt(req_cnt), .req_data(req_data),
        .busy(busy)
    );

    tsw_nvm #(.ADDR_W(ADDR_W), .MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)) u_nvm (
        .clk(clk), .rst_n(rst_n), .stage_we(stage_we), .flag_we(flag_we),
        .flag_val(flag_val), .byte_we(byte_we), .byte_addr(byte_addr),
        .byte_data(byte_data), .page_we(page_we), .req_addr(req_addr),
        .req_cnt(req_cnt), .req_data(req_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .rec_addr(rec_addr), .rec_cnt(rec_cnt), .rec_data(rec_data), .rec_valid(rec_valid)
    );
endmodule

// File: tb/tb_tear_safe_writer.sv
`timescale 1ns/1ps
module tb_tear_safe_writer;
    localparam int WR = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_fail = 1'b0;
    logic        wr_req = 1'b0;
    logic        safe_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [2:0]  wr_cnt = '0;
    logic [63:0] wr_data = '0;
    logic        busy;
    logic [5:0]  rd_addr = '0;
    logic [7:0]  rd_data;

    logic [7:0]  exp_mem [64];
    int          n_checks = 0;
    int          n_fail = 0;
    int          seed = 1;

    always #2.5 clk = ~clk;

    tear_safe_writer #(.ADDR_W(6), .MAX_BYTES(8), .WR_CYCLES(WR)) dut (
        .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .wr_req(wr_req),
        .safe_en(safe_en), .wr_addr(wr_addr), .wr_cnt(wr_cnt), .wr_data(wr_data),
        .busy(busy), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_data(input int s);
        logic [63:0] d;
        for (int i = 0; i < 8; i++) d[8*i +: 8] = 8'((s * 29 + i * 13 + 7) & 255);
        return d;
    endfunction

    task automatic verify_all(input string req);
        int bad = 0;
        int first = -1;
        for (int a = 0; a < 64; a++) begin
            rd_addr = 6'(a);
            #0.001;
            if (rd_data !== exp_mem[a]) begin
                bad++;
                if (first < 0) first = a;
            end
        end
        if (first >= 0) begin
            rd_addr = 6'(first);
            #0.001;
            $display("  mismatch at %0d: got %0h want %0h", first, rd_data, exp_mem[first]);
        end
        check(bad == 0, req, bad, 0);
    endtask

    // counts edges from now until busy is seen low at a falling edge
    task automatic count_busy(output int n);
        n = 0;
        forever begin
            @(posedge clk); n++; @(negedge clk);
            if (!busy || n > 1000) break;
        end
    endtask

    task automatic run_write(input logic [5:0] a, input logic [2:0] c, input bit at,
                             input int fail_k, input bit poke);
        logic [63:0] d;
        int n, exp_n, cnt;
        bit commit;
        d   = mk_data(seed);
        seed++;
        cnt = int'(c) + 1;
        @(negedge clk);
        wr_addr = a; wr_cnt = c; wr_data = d; safe_en = at; wr_req = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_req = 1'b0;
        if (fail_k == 0) begin
            n = 0;
            forever begin
                // R4: a second request raised mid-write must be ignored
                if (poke && n == 1) begin
                    wr_req = 1'b1; wr_addr = a ^ 6'h20; safe_en = 1'b0; wr_data = ~d;
                end else begin
                    wr_req = 1'b0;
                end
                @(posedge clk); n++; @(negedge clk);
                if (!busy || n > 1000) break;
            end
            wr_req = 1'b0;
            exp_n  = at ? WR * (cnt + 3) : WR;
            check(n == exp_n, at ? (poke ? "R4 duration" : "R3 duration") : "R2 duration",
                  n, exp_n);
            commit = 1'b1;
        end else begin
            repeat (fail_k - 1) begin @(posedge clk); @(negedge clk); end
            pwr_fail = 1'b1;
            @(posedge clk); @(negedge clk);
            check(busy == 1'b1, "R5 busy at fail", int'(busy), 1);
            repeat (2) begin @(posedge clk); @(negedge clk); end
            check(busy == 1'b1, "R5 busy held", int'(busy), 1);
            pwr_fail = 1'b0;
            commit = at && (fail_k > 2 * WR);
            count_busy(n);
            exp_n = commit ? 1 + WR * (cnt + 1) : 1;
            check(n == exp_n, "R6 restart duration", n, exp_n);
        end
        if (commit)
            for (int i = 0; i < cnt; i++) exp_mem[(int'(a) + i) & 63] = d[8*i +: 8];
        if (fail_k != 0) verify_all(at ? "R7 window all-old/all-new" : "R8 direct abort");
        else             verify_all(poke ? "R4 no side write" : "R9 window and neighbours");
    endtask

    initial begin
        #(5.0 * 150000);
        $display("FAIL watchdog expired actual=hung expected=done");
        n_checks++;
        n_fail++;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int n;
        for (int a = 0; a < 64; a++) exp_mem[a] = 8'hFF;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        // R1: erased array, idle
        check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
        verify_all("R1 erased");

        // R2: direct writes, including a wrapping window
        run_write(6'd0,  3'd0, 1'b0, 0, 1'b0);
        run_write(6'd5,  3'd7, 1'b0, 0, 1'b0);
        run_write(6'd60, 3'd5, 1'b0, 0, 1'b0);
        run_write(6'd33, 3'd3, 1'b0, 0, 1'b0);

        // R3: staged writes of several lengths, including a wrapping window
        run_write(6'd10, 3'd0, 1'b1, 0, 1'b0);
        run_write(6'd20, 3'd7, 1'b1, 0, 1'b0);
        run_write(6'd62, 3'd3, 1'b1, 0, 1'b0);

        // R4: request while busy
        run_write(6'd44, 3'd2, 1'b1, 0, 1'b1);

        // R6: power loss while idle, nothing to replay
        @(negedge clk); pwr_fail = 1'b1;
        repeat (3) begin @(posedge clk); @(negedge clk); end
        check(busy == 1'b1, "R5 busy while idle fail", int'(busy), 1);
        pwr_fail = 1'b0;
        count_busy(n);
        check(n == 1, "R6 no replay when clean", n, 1);
        verify_all("R6 memory kept");

        // R7: sweep failure edge over every cycle of a staged write
        for (int ci = 0; ci < 3; ci++) begin
            int c = (ci == 0) ? 0 : ((ci == 1) ? 2 : 7);
            for (int k = 1; k <= WR * (c + 4) - WR; k++)
                run_write(6'((17 * c + 3) & 63), 3'(c), 1'b1, k, 1'b0);
        end

        // R8: failures inside a direct write cycle
        for (int k = 1; k <= WR; k++) run_write(6'd50, 3'd4, 1'b0, k, 1'b0);

        // final clean write after all the interruptions
        run_write(6'd30, 3'd6, 1'b1, 0, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule